// File: doc/BRIEF.md
# Key Event Queue with Status Encoding

This block buffers up to sixteen debounced key events from a 64-key matrix and hands them to a host one byte at a time. A key number is column × 8 + row. The producer offers one of two kinds of event:

- a key event, made of a 6-bit key number and a release flag;
- an autorepeat marker.

The host issues a single-cycle pop strobe. In the cycle after the pop, an 8-bit readout code appears. The code carries the oldest event together with queue status: whether more entries follow, whether the event was a release, and whether the queue is empty or has overflowed.

The write side is a valid/ready stream. `evt_ready` is high whenever fewer than sixteen entries are stored. It is advisory. The producer may assert `evt_valid` while `evt_ready` is low, but such an event is not stored: it is dropped and latches a sticky overflow flag. The queue's full state is judged at the start of the cycle, so a push in a cycle where the queue is full is dropped even if a pop happens in the same cycle. The read side is a plain strobe with no back-pressure. The readout register holds its value until the next pop. Stored entries never change without a pop, so the contents survive any idle period, such as a sleep state. `level` reports the number of stored entries, for use by interrupt logic.

Top module: `kq_event_queue`

## Requirements
- R1: After reset, `rd_code` is 0x3F, `level` is 0 and `evt_ready` is 1.
- R2: Up to 16 events are stored and returned oldest first. `level` equals the number of stored entries.
- R3: For keys 0 to 61, the code is {more, release, key[5:0]}. Bit 7 (more) is 1 when at least one entry remains after this one. Bit 6 is 1 for a release and 0 for a press.
- R4: Key 62 reads 0xBE when pressed and 0xFE when released. Key 63 reads 0xBF when pressed and 0xFF when released. Bit 7 is 1 for these keys whatever remains in the queue.
- R5: An autorepeat marker reads 0x7E when more entries follow it and 0x3E when it is the last entry. While `evt_repeat` is 1, the `evt_key` and `evt_release` inputs are ignored.
- R6: A pop on an empty queue (with no overflow pending) returns 0x3F and leaves `level` at 0.
- R7: With 16 entries stored, `evt_ready` is 0. A push is dropped and `level` stays 16.
- R8: After a dropped push, the next pop returns 0x7F and removes no entry. Later pops return the stored entries in order. Once 0x7F has been read, an empty queue reads 0x3F again.
- R9: Without a pop, `rd_code` and the stored entries do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Producer offers an event this cycle |
| evt_ready | output | 1 | Queue has room (advisory) |
| evt_key | input | 6 | Key number, column × 8 + row |
| evt_release | input | 1 | 1 = release, 0 = press |
| evt_repeat | input | 1 | Event is an autorepeat marker |
| pop | input | 1 | Host read strobe |
| rd_code | output | 8 | Readout code, updated in the cycle after a pop |
| level | output | 5 | Number of stored entries |

## Verification
The hardest situation to reach is the overflow recovery. The queue must first be filled completely and then pushed past full. The bench must then show that the 0x7F read consumes nothing, and that all sixteen older entries still come out in order with the correct more-bit on the last one. The stimulus fills the queue with alternating presses and releases and offers two extra events while `evt_ready` is low. It then drains through a scoreboard model and confirms that a further empty pop returns 0x3F rather than 0x7F.

// File: rtl/kq_pkg.sv
package kq_pkg;
  localparam int KEY_W = 6;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] CODE_EMPTY = 8'h3F;
  localparam logic [CODE_W-1:0] CODE_OVF   = 8'h7F;
  localparam logic [KEY_W-1:0]  KEY_RPT    = 6'h3E;

  typedef struct packed {
    logic             rpt;
    logic             rel;
    logic [KEY_W-1:0] key;
  } kq_entry_t;
endpackage

// File: rtl/kq_store.sv
module kq_store
  import kq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  kq_entry_t        wr_entry,
  input  logic             take,
  output kq_entry_t        head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             drop
);
  kq_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             push_ok, take_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign take_ok = take && !empty;
  assign drop    = push && full;
  assign head    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (take_ok) rd_ptr <= nxt(rd_ptr);
      case ({push_ok, take_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R2
  AST_LEVEL_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !take) |=> count == CNT_W'($past(count) + 1'b1)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !take) |=> (full && $stable(wr_ptr))); // R7
  AST_EMPTY_TAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && empty) |=> $stable(rd_ptr)); // R6
endmodule

// File: rtl/kq_ovf.sv
module kq_ovf (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic shown,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (drop)   flag <= 1'b1;
    else if (shown)  flag <= 1'b0;
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> flag); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !shown) |=> flag); // R8
endmodule

// File: rtl/kq_encode.sv
module kq_encode
  import kq_pkg::*;
(
  input  kq_entry_t         ent,
  input  logic              more,
  input  logic              empty,
  input  logic              ovf,
  output logic [CODE_W-1:0] code
);
  logic high_key;
  assign high_key = (ent.key[KEY_W-1:1] == '1);

  always_comb begin
    if (ovf)           code = CODE_OVF;
    else if (empty)    code = CODE_EMPTY;
    else if (ent.rpt)  code = {1'b0, more, KEY_RPT};
    else if (high_key) code = {1'b1, ent.rel, ent.key};
    else               code = {more, ent.rel, ent.key};
  end
endmodule

// File: rtl/kq_event_queue.sv
module kq_event_queue
  import kq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [5:0]       evt_key,
  input  logic             evt_release,
  input  logic             evt_repeat,
  input  logic             pop,
  output logic [7:0]       rd_code,
  output logic [CNT_W-1:0] level
);
  kq_entry_t   wr_entry, head;
  logic        full, empty, drop, ovf_flag, take, more;
  logic [7:0]  next_code;

  always_comb begin
    wr_entry.rpt = evt_repeat;
    wr_entry.rel = evt_repeat ? 1'b0 : evt_release;
    wr_entry.key = evt_repeat ? KEY_RPT : evt_key;
  end

  assign take = pop && !ovf_flag;
  assign more = (level > CNT_W'(1));

  kq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(evt_valid), .wr_entry(wr_entry),
    .take(take), .head(head), .count(level), .full(full),
    .empty(empty), .drop(drop)
  );

  kq_ovf u_ovf (
    .clk(clk), .rst_n(rst_n), .drop(drop), .shown(pop), .flag(ovf_flag)
  );

  kq_encode u_enc (
    .ent(head), .more(more), .empty(empty), .ovf(ovf_flag), .code(next_code)
  );

  assign evt_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n)   rd_code <= CODE_EMPTY;
    else if (pop) rd_code <= next_code;
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> $stable(rd_code)); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && level == '0 && !ovf_flag) |=> rd_code == 8'h3F); // R6
  AST_OVF_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && ovf_flag) |=> (rd_code == 8'h7F && $stable(level))); // R8
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (level == CNT_W'(DEPTH)) |-> !evt_ready); // R7
endmodule

// File: tb/kq_event_queue_tb.sv
module kq_event_queue_tb;
  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_release = 0, evt_repeat = 0, pop = 0;
  logic [5:0] evt_key = 0;
  logic evt_ready;
  logic [7:0] rd_code;
  logic [4:0] level;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  kq_event_queue u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_key(evt_key), .evt_release(evt_release), .evt_repeat(evt_repeat),
    .pop(pop), .rd_code(rd_code), .level(level)
  );

  logic [7:0] mq[$];   // model entries {rpt, rel, key}
  logic       m_ovf = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_evt(input logic [5:0] k, input logic rel, input logic rpt);
    @(negedge clk);
    evt_valid = 1; evt_key = k; evt_release = rel; evt_repeat = rpt;
    if (mq.size() == 16) m_ovf = 1;
    else mq.push_back({rpt, rpt ? 1'b0 : rel, rpt ? 6'h3E : k});
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic do_pop(input string req);
    logic [7:0] e, c;
    logic more;
    @(negedge clk);
    if (m_ovf) begin c = 8'h7F; m_ovf = 0; end
    else if (mq.size() == 0) c = 8'h3F;
    else begin
      e = mq.pop_front();
      more = (mq.size() > 0);
      if (e[7]) c = {1'b0, more, 6'h3E};
      else if (e[5:1] == 5'h1F) c = {1'b1, e[6], e[5:0]};
      else c = {more, e[6], e[5:0]};
    end
    exp_q.push_back(c); tag_q.push_back(req);
    pop = 1;
    @(negedge clk);
    pop = 0;
  endtask

  always @(posedge clk) pend <= pop;

  always @(negedge clk) begin
    if (pend) begin
      logic [7:0] x;
      string t;
      x = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_code == x, t, rd_code, x);
    end
  end

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rd_code == 8'h3F, "R1", rd_code, 8'h3F);
    chk(level == 0, "R1", level, 0);
    chk(evt_ready == 1, "R1", evt_ready, 1);

    do_pop("R6");
    @(negedge clk);
    chk(level == 0, "R6", level, 0);

    push_evt(6'd5, 0, 0);
    push_evt(6'd10, 1, 0);
    chk(level == 2, "R2", level, 2);
    do_pop("R3");
    do_pop("R3");

    push_evt(6'd63, 0, 0);
    push_evt(6'd62, 1, 0);
    push_evt(6'd63, 1, 0);
    do_pop("R4"); do_pop("R4"); do_pop("R4");
    do_pop("R6");

    push_evt(6'd7, 1, 1);   // key/release ignored for repeat
    push_evt(6'd1, 0, 0);
    do_pop("R5"); do_pop("R3");
    push_evt(6'd20, 1, 1);
    do_pop("R5");

    for (int i = 0; i < 16; i++) push_evt(6'(i * 3), 1'(i % 2), 0);
    @(negedge clk);
    chk(level == 16, "R2", level, 16);
    chk(evt_ready == 0, "R7", evt_ready, 0);
    push_evt(6'd40, 0, 0);
    push_evt(6'd41, 1, 0);
    @(negedge clk);
    chk(level == 16, "R7", level, 16);
    do_pop("R8");
    @(negedge clk);
    chk(level == 16, "R8", level, 16);
    for (int i = 0; i < 16; i++) do_pop("R2");
    do_pop("R8");

    push_evt(6'd12, 0, 0);
    push_evt(6'd13, 0, 0);
    push_evt(6'd14, 1, 0);
    do_pop("R9");
    @(negedge clk);
    held = rd_code;
    repeat (20) @(negedge clk);
    chk(rd_code == held, "R9", rd_code, held);
    chk(level == 2, "R9", level, 2);
    do_pop("R9"); do_pop("R9");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule